// File: doc/BRIEF.md
# USB Host Wrapper Control Register Bank

This block is the register bank of the wrapper around a USB host subsystem that contains both a full-speed (OHCI) and a high-speed (EHCI) host controller. It answers a simple 32-bit register bus. Each access presents a byte offset, a read strobe or a write strobe, and write data. The bank gives back registered read data and a same-cycle error flag.

The bank holds three writable configuration registers: system configuration, host configuration and debug control. Each has its own reset value and its own mask of bits that can be written. A constant revision word and a status word that reports every reset as complete are both read-only. Writing the soft-reset bit of the system configuration register reloads the whole bank with its reset values. The hardware reset input does the same.

Top module: `usbhw_ctl_regs`

## Requirements
- R1: After the synchronous reset `rst` the system configuration (offset 0x10) reads 0x1, the host configuration (offset 0x40) reads 0x700 and the debug control (offset 0x44) reads 0x20.
- R2: A read of offset 0x00 returns the revision value 0x10.
- R3: A read of offset 0x14 returns 0x7, in which bit 0 is overall reset done, bit 1 is OHCI reset done and bit 2 is EHCI reset done.
- R4: A write to offset 0x10 without bit 1 set stores the write data ANDed with 0x311D.
- R5: A write to offset 0x40 stores the write data ANDed with 0x1F3D.
- R6: A write to offset 0x44 stores the write data ANDed with 0xF00FF.
- R7: A write to offset 0x10 with bit 1 (soft reset) set returns all three writable registers to their R1 values in the next cycle, overriding the written data. Bit 1 always reads back as 0.
- R8: A write to offset 0x00 or 0x14 changes no register and raises `err` in the same cycle.
- R9: A read or write at any offset other than 0x00, 0x10, 0x14, 0x40 and 0x44 (including unaligned offsets) raises `err` in the same cycle. Such a read returns 0, and such a write changes no register.
- R10: Read data appears on `rdata` in the cycle after `rd_en`. It reflects register contents from before any write in the same cycle, and `rdata` is 0 in a cycle that follows no read.
- R11: `err` is low in every cycle that has no access, no write to a read-only offset and no access to an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (12) | Byte offset of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, one cycle after `rd_en` |
| err | output | 1 | Bad access flag, same cycle as the access |

## Verification
The bench writes all-ones and mixed patterns to each writable register. A wrong mask shows up as extra or missing bits on read-back. It sets the soft-reset bit together with other bits after all three registers have been changed, so a bank that stored the written value, or reset only the system register, reads back the wrong words. It writes to the read-only offsets, to unaligned offsets and to holes in the map. A design that decoded only some address bits would corrupt a register or miss the error pulse. A read issued in the same cycle as a write, and idle cycles after reads, show whether read data was taken before the write and whether it returns to zero.

// File: rtl/usbhw_ctl_pkg.sv
package usbhw_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_CFG  = 3;
    localparam int SRST_BIT = 1;

    localparam int OFF_REV  = 'h00;
    localparam int OFF_SYS  = 'h10;
    localparam int OFF_STAT = 'h14;
    localparam int OFF_HOST = 'h40;
    localparam int OFF_DBG  = 'h44;

    localparam logic [DATA_W-1:0] REV_VALUE  = 32'h0000_0010;
    localparam logic [DATA_W-1:0] STAT_VALUE = 32'h0000_0007;

    // Index of each writable register in the configuration array.
    localparam int IDX_SYS  = 0;
    localparam int IDX_HOST = 1;
    localparam int IDX_DBG  = 2;

    localparam logic [DATA_W-1:0] CFG_RST  [NUM_CFG] = '{32'h0000_0001, 32'h0000_0700, 32'h0000_0020};
    localparam logic [DATA_W-1:0] CFG_MASK [NUM_CFG] = '{32'h0000_311D, 32'h0000_1F3D, 32'h000F_00FF};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REV,
        SEL_STAT,
        SEL_SYS,
        SEL_HOST,
        SEL_DBG
    } sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [DATA_W-1:0] data;
    } acc_t;

    function automatic logic is_read_only(sel_e s);
        return (s == SEL_REV) || (s == SEL_STAT);
    endfunction

    function automatic sel_e cfg_sel(int idx);
        case (idx)
            IDX_SYS:  return SEL_SYS;
            IDX_HOST: return SEL_HOST;
            default:  return SEL_DBG;
        endcase
    endfunction

endpackage

// File: rtl/usbhw_addr_dec.sv
module usbhw_addr_dec
    import usbhw_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_REV))  sel = SEL_REV;
        if (addr == ADDR_W'(OFF_SYS))  sel = SEL_SYS;
        if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        if (addr == ADDR_W'(OFF_HOST)) sel = SEL_HOST;
        if (addr == ADDR_W'(OFF_DBG))  sel = SEL_DBG;
    end
endmodule

// File: rtl/usbhw_field_reg.sv
module usbhw_field_reg
    import usbhw_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter logic [DATA_W-1:0] MASK    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= RST_VAL;
        else if (we)
            q <= wdata & MASK;
    end

    // R4, R5, R6: no bit outside the writable mask is ever held
    p_in_mask_r4: assert property (@(posedge clk) disable iff (rst)
        we && !clr |=> (q & ~MASK) == '0);

    // R7: a clear wins over a write in the same cycle
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> q == RST_VAL);
endmodule

// File: rtl/usbhw_cfg_bank.sv
module usbhw_cfg_bank
    import usbhw_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sel_e              sel,
    input  acc_t              acc,
    output logic [DATA_W-1:0] cfg_q [NUM_CFG]
);
    logic soft_rst;
    assign soft_rst = acc.wr && (sel == SEL_SYS) && acc.data[SRST_BIT];

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        logic we_i;
        assign we_i = acc.wr && (sel == cfg_sel(i));
        usbhw_field_reg #(
            .RST_VAL (CFG_RST[i]),
            .MASK    (CFG_MASK[i])
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .clr   (soft_rst),
            .we    (we_i),
            .wdata (acc.data),
            .q     (cfg_q[i])
        );
    end

    // R7: soft reset reloads every register of the bank
    p_soft_reload_r7: assert property (@(posedge clk) disable iff (rst)
        acc.wr && sel == SEL_SYS && acc.data[SRST_BIT] |=>
            cfg_q[IDX_SYS] == CFG_RST[IDX_SYS] && cfg_q[IDX_HOST] == CFG_RST[IDX_HOST]
            && cfg_q[IDX_DBG] == CFG_RST[IDX_DBG]);

    // R8, R9: writes outside the writable registers leave the bank untouched
    p_ro_stable_r8: assert property (@(posedge clk) disable iff (rst)
        acc.wr && (is_read_only(sel) || sel == SEL_NONE) |=>
            $stable(cfg_q[IDX_SYS]) && $stable(cfg_q[IDX_HOST]) && $stable(cfg_q[IDX_DBG]));

    // R7: the soft-reset bit never reads back as set
    p_srst_zero_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !cfg_q[IDX_SYS][SRST_BIT]);
endmodule

// File: rtl/usbhw_rd_mux.sv
module usbhw_rd_mux
    import usbhw_ctl_pkg::*;
(
    input  sel_e              sel,
    input  logic [DATA_W-1:0] cfg_q [NUM_CFG],
    output logic [DATA_W-1:0] rd_val
);
    always_comb begin
        case (sel)
            SEL_REV:  rd_val = REV_VALUE;
            SEL_STAT: rd_val = STAT_VALUE;
            SEL_SYS:  rd_val = cfg_q[IDX_SYS];
            SEL_HOST: rd_val = cfg_q[IDX_HOST];
            SEL_DBG:  rd_val = cfg_q[IDX_DBG];
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/usbhw_ctl_regs.sv
module usbhw_ctl_regs
    import usbhw_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    sel_e              sel;
    acc_t              acc;
    logic [DATA_W-1:0] cfg_q [NUM_CFG];
    logic [DATA_W-1:0] rd_val;

    assign acc = '{rd: rd_en, wr: wr_en, data: wdata};

    usbhw_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    usbhw_cfg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .acc   (acc),
        .cfg_q (cfg_q)
    );

    usbhw_rd_mux u_mux (
        .sel    (sel),
        .cfg_q  (cfg_q),
        .rd_val (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_val : '0;
    end

    assign err = ((acc.rd || acc.wr) && sel == SEL_NONE) || (acc.wr && is_read_only(sel));

    // R11: no error pulse without an access
    p_err_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en && !wr_en |-> !err);

    // R10: read data returns to zero after a cycle with no read
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);

    // R2: the revision word is constant
    p_rev_const_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == ADDR_W'(OFF_REV) |=> rdata == REV_VALUE);

    // R3: the status word always reports every reset done
    p_stat_const_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == ADDR_W'(OFF_STAT) |=> rdata == STAT_VALUE);

    // R9: an unmapped read returns zero
    p_hole_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en && err && !wr_en |=> rdata == '0);
endmodule

// File: tb/usbhw_ctl_regs_test.sv
module usbhw_ctl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // behavioural model state
    logic [31:0] m_sys = 32'h1, m_host = 32'h700, m_dbg = 32'h20;
    logic [31:0] m_rdata = '0;
    string       rd_tag = "R10";

    usbhw_ctl_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        case (int'(a))
            'h00: return 32'h10;
            'h10: return m_sys;
            'h14: return 32'h7;
            'h40: return m_host;
            'h44: return m_dbg;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_err(logic [AW-1:0] a, logic r, logic w);
        logic mapped, ro;
        mapped = (a == 'h00) || (a == 'h10) || (a == 'h14) || (a == 'h40) || (a == 'h44);
        ro     = (a == 'h00) || (a == 'h14);
        return ((r || w) && !mapped) || (w && ro);
    endfunction

    // model update at every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_sys = 32'h1; m_host = 32'h700; m_dbg = 32'h20; m_rdata = '0;
        end else begin
            m_rdata = rd_en ? m_read(addr) : 32'h0;
            if (wr_en) begin
                if (addr == 'h10 && wdata[1]) begin
                    m_sys = 32'h1; m_host = 32'h700; m_dbg = 32'h20;
                end else if (addr == 'h10) m_sys = wdata & 32'h311D;
                else if (addr == 'h40) m_host = wdata & 32'h1F3D;
                else if (addr == 'h44) m_dbg = wdata & 32'hF00FF;
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // compare read data against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) check(rdata, m_rdata, rd_tag);
    end

    // one access per cycle; err checked in the cycle of the access
    task automatic acc(input logic r, input logic w, input int a, input logic [31:0] d, input string tag);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = AW'(a); wdata = d; rd_tag = tag;
        #1;
        check({31'b0, err}, {31'b0, m_err(AW'(a), r, w)}, tag);
    endtask

    task automatic idle(input string tag);
        acc(1'b0, 1'b0, 0, 32'h0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values; the read data is checked on the next clock
        acc(1, 0, 'h10, 0, "R1");
        acc(1, 0, 'h40, 0, "R1");
        acc(1, 0, 'h44, 0, "R1");
        acc(1, 0, 'h00, 0, "R2");
        acc(1, 0, 'h14, 0, "R3");
        idle("R10");
        idle("R11");
        // R4 system configuration mask (bit 1 clear)
        acc(0, 1, 'h10, 32'hFFFF_FFFD, "R4");
        acc(1, 0, 'h10, 0, "R4");
        acc(0, 1, 'h10, 32'h0000_0000, "R4");
        acc(1, 0, 'h10, 0, "R4");
        acc(0, 1, 'h10, 32'hA5A5_A5A5 & ~32'h2, "R4");
        acc(1, 0, 'h10, 0, "R4");
        // R5 host configuration mask
        acc(0, 1, 'h40, 32'hFFFF_FFFF, "R5");
        acc(1, 0, 'h40, 0, "R5");
        acc(0, 1, 'h40, 32'h0000_0000, "R5");
        acc(1, 0, 'h40, 0, "R5");
        acc(0, 1, 'h40, 32'h5A5A_C3C3, "R5");
        acc(1, 0, 'h40, 0, "R5");
        // R6 debug control mask
        acc(0, 1, 'h44, 32'hFFFF_FFFF, "R6");
        acc(1, 0, 'h44, 0, "R6");
        acc(0, 1, 'h44, 32'hA5A5_A5A5, "R6");
        acc(1, 0, 'h44, 0, "R6");
        // R8 writes to read-only offsets
        acc(0, 1, 'h00, 32'hFFFF_FFFF, "R8");
        acc(0, 1, 'h14, 32'h0000_0000, "R8");
        acc(1, 0, 'h00, 0, "R8");
        acc(1, 0, 'h14, 0, "R8");
        acc(1, 0, 'h10, 0, "R8");
        acc(1, 0, 'h40, 0, "R8");
        acc(1, 0, 'h44, 0, "R8");
        // R9 unmapped, unaligned and out-of-map offsets
        acc(1, 0, 'h20, 0, "R9");
        acc(0, 1, 'h48, 32'hFFFF_FFFF, "R9");
        acc(1, 0, 'h13, 0, "R9");
        acc(0, 1, 'h11, 32'hFFFF_FFFF, "R9");
        acc(0, 1, 'h41, 32'h0, "R9");
        acc(1, 0, 'hFFC, 0, "R9");
        acc(0, 1, 'h410, 32'h0, "R9");
        acc(1, 0, 'h10, 0, "R9");
        acc(1, 0, 'h40, 0, "R9");
        acc(1, 0, 'h44, 0, "R9");
        // R10 read and write in the same cycle returns the old value
        acc(1, 1, 'h40, 32'h0000_0004, "R10");
        acc(1, 1, 'h40, 32'h0000_1000, "R10");
        acc(1, 0, 'h40, 0, "R10");
        idle("R10");
        // R7 soft reset overrides written data and reloads the whole bank
        acc(0, 1, 'h44, 32'h0000_0011, "R7");
        acc(0, 1, 'h10, 32'hFFFF_FFFF, "R7");
        acc(1, 0, 'h10, 0, "R7");
        acc(1, 0, 'h40, 0, "R7");
        acc(1, 0, 'h44, 0, "R7");
        acc(0, 1, 'h40, 32'h0000_0001, "R7");
        acc(0, 1, 'h10, 32'h0000_0002, "R7");
        acc(1, 0, 'h10, 0, "R7");
        acc(1, 0, 'h40, 0, "R7");
        idle("R11");
        idle("R11");
        // R1 hardware reset after changes
        acc(0, 1, 'h44, 32'h0000_00FF, "R1");
        @(negedge clk); rd_en = 0; wr_en = 0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        acc(1, 0, 'h44, 0, "R1");
        acc(1, 0, 'h10, 0, "R1");
        idle("R10");
        idle("R10");
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule